// File: doc/BRIEF.md
# Priority Interrupt Controller with Masking

The controller collects interrupt events from a set of peripheral sources and a small group of trap sources. It decides which one a simple CPU should service next. Each peripheral source has three settings: a sticky pending flag, an enable bit and a three-bit priority. All three are read and written through a narrow register port. Trap sources have sticky status bits that software clears by writing ones. The controller holds the CPU's four-bit priority level. Levels 0 to 7 belong to peripheral sources and levels 8 to 15 to traps. A request is raised only when its source ranks strictly above that level.

The CPU accepts a request with a one-cycle acknowledge pulse. On that pulse the controller records the winning source index, pushes the old level onto an internal stack and raises the level. A one-cycle return pulse pops the stack and restores the saved level. Three controls shape which requests get through. A nesting-disable bit makes every accepted peripheral interrupt lift the level to 7. A timed masking window blocks peripheral levels 1 to 6 for a loaded number of cycles. Software can also write the level directly.

Request/acknowledge rule: `vec_req` is re-evaluated every cycle from the current state. It stays high for as long as a qualifying source exists. `vec_idx` and `vec_lvl` describe the current winner and may change before the acknowledge. The values present in the acknowledge cycle are the ones taken. An acknowledge while `vec_req` is low has no effect.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every source priority reads 4, all flags, enables and trap status bits read 0, the CPU level is 0, `stk_ovf` is 0 and `vec_req` is low.
- R2: Register words at addresses 0..N_SRC-1 hold one source each: bit 0 is the flag, bit 1 the enable and bits 4:2 the priority. A write replaces all three fields. A `src_evt` pulse sets the flag, and it wins over a same-cycle write that clears it.
- R3: A peripheral source qualifies only if its flag and enable are both 1, its priority is non-zero and its priority is strictly greater than the CPU level.
- R4: Among qualifying peripheral sources the highest priority wins, and the lowest index wins a tie. Any qualifying trap beats every peripheral source, and among traps the higher number wins. `vec_idx` is the source index for peripheral sources and N_SRC+t for trap t. `vec_lvl` is the priority for a peripheral source and 8+t for trap t.
- R5: An acknowledge while `vec_req` is high loads `act_idx` with `vec_idx`, pushes the old level and sets the CPU level to `vec_lvl` on the next cycle.
- R6: When the nesting-disable bit (bit 4 of the control word at address N_SRC) is 1, accepting a peripheral source sets the CPU level to 7 instead.
- R7: A return pulse restores the most recently pushed level. A source whose flag is still set is requested again as soon as it outranks the restored level.
- R8: `mask_go` loads `mask_len` into a window counter. For the following `mask_len` cycles peripheral priorities 1 to 6 are blocked, while priority 7 and traps still pass.
- R9: A write to the control word sets the CPU level to bits 2:0 only while the level is below 8; otherwise the level is left unchanged. Writing 7 blocks every peripheral source, and writing the earlier value back lets them through again.
- R10: A `trap_evt` pulse sets trap status bit t in the word at address N_SRC+1. Writing a 1 to that bit clears it. Trap t has level 8+t and is not blocked by the enables, the masking window or a level-7 write.
- R11: The level stack holds 8 entries. A push onto a full stack sets `stk_ovf`, which stays set until reset. A return with an empty stack leaves the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | N_SRC | Per-source event pulses that set flags |
| trap_evt | input | N_TRAP | Per-trap event pulses that set status bits |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address for reads and writes |
| reg_wdata | input | 5 | Register write data |
| reg_rdata | output | 5 | Register read data (combinational on reg_addr) |
| mask_go | input | 1 | Load the masking window counter |
| mask_len | input | MASK_W | Masking window length in cycles |
| vec_req | output | 1 | Interrupt request to the CPU |
| vec_idx | output | IW | Index of the current winning source |
| vec_lvl | output | 4 | Level of the current winning source |
| vec_ack | input | 1 | CPU accepts the request (one-cycle pulse) |
| act_idx | output | IW | Index captured at the last acknowledge |
| ret_pulse | input | 1 | CPU returns from a handler (one-cycle pulse) |
| cpu_lvl | output | 4 | Current CPU priority level |
| stk_ovf | output | 1 | Sticky level-stack overflow |

## Verification
Some relations are checked by assertions on every cycle. A raised request always outranks the CPU level. A request at level 8 or above always carries a trap index. During a masking window the only peripheral request that can appear is at level 7. Every acknowledge captures the index and sets the new level, or level 7 under nesting-disable. The overflow flag never drops. The bench scenarios cover what depends on history and register contents: lowest-index tie breaking, an event winning over a same-cycle flag clear, a flag that is still set coming back after a return, the exact length of the masking window, a level write ignored while a trap runs, and the order in which levels unwind from a full stack.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int DW = 5;
  localparam int LW = 4;
  localparam logic [2:0] PRIO_AT_RESET = 3'd4;
  localparam logic [2:0] PRIO_TOP_USER = 3'd7;
endpackage

// File: rtl/pic_src_regs.sv
module pic_src_regs
  import pic_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int AW    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_SRC-1:0]      evt,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_sel,
  input  logic [DW-1:0]         wr_data,
  output logic [N_SRC-1:0]      flag,
  output logic [N_SRC-1:0]      en,
  output logic [N_SRC-1:0][2:0] prio
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag[i] <= 1'b0;
        en[i]   <= 1'b0;
        prio[i] <= PRIO_AT_RESET;
      end else begin
        if (wr_en && wr_sel == AW'(i)) begin
          flag[i] <= wr_data[0];
          en[i]   <= wr_data[1];
          prio[i] <= wr_data[4:2];
        end
        if (evt[i]) flag[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pic_select.sv
module pic_select
  import pic_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int N_TRAP = 4,
  parameter int IW     = 4
) (
  input  logic [N_SRC-1:0]      flag,
  input  logic [N_SRC-1:0]      en,
  input  logic [N_SRC-1:0][2:0] prio,
  input  logic [N_TRAP-1:0]     trap_flag,
  input  logic [LW-1:0]         cur_lvl,
  input  logic                  mask_on,
  output logic                  req,
  output logic [IW-1:0]         idx,
  output logic [LW-1:0]         lvl
);
  logic       u_hit, t_hit;
  logic [2:0] u_best;
  int         u_sel, t_sel;

  always_comb begin
    u_hit  = 1'b0;
    u_best = 3'd0;
    u_sel  = 0;
    for (int i = 0; i < N_SRC; i++) begin
      if (flag[i] && en[i] && prio[i] != 3'd0 &&
          {1'b0, prio[i]} > cur_lvl &&
          (!mask_on || prio[i] == PRIO_TOP_USER) &&
          (!u_hit || prio[i] > u_best)) begin
        u_hit  = 1'b1;
        u_best = prio[i];
        u_sel  = i;
      end
    end
    t_hit = 1'b0;
    t_sel = 0;
    for (int t = 0; t < N_TRAP; t++) begin
      if (trap_flag[t] && LW'(8 + t) > cur_lvl) begin
        t_hit = 1'b1;
        t_sel = t;
      end
    end
    req = t_hit | u_hit;
    if (t_hit) begin
      idx = IW'(N_SRC + t_sel);
      lvl = LW'(8 + t_sel);
    end else begin
      idx = IW'(u_sel);
      lvl = {1'b0, u_best};
    end
  end
endmodule

// File: rtl/pic_level_stack.sv
module pic_level_stack
  import pic_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [LW-1:0] push_lvl,
  input  logic          pop,
  input  logic          sw_we,
  input  logic [LW-1:0] sw_lvl,
  output logic [LW-1:0] cur_lvl,
  output logic          ovf
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int XW = $clog2(DEPTH);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  logic [LW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr;
  logic [PW-1:0] ptr_dn;

  assign ptr_dn = ptr - 1'b1;

  always_ff @(posedge clk) begin
    if (push && ptr < FULL) mem[ptr[XW-1:0]] <= cur_lvl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      cur_lvl <= '0;
      ovf     <= 1'b0;
    end else if (push) begin
      cur_lvl <= push_lvl;
      if (ptr < FULL) ptr <= ptr + 1'b1;
      else            ovf <= 1'b1;
    end else if (pop) begin
      if (ptr != '0) begin
        cur_lvl <= mem[ptr_dn[XW-1:0]];
        ptr     <= ptr_dn;
      end
    end else if (sw_we) begin
      cur_lvl <= sw_lvl;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N_SRC     = 8,
  parameter int N_TRAP    = 4,
  parameter int STK_DEPTH = 8,
  parameter int MASK_W    = 8,
  localparam int AW       = $clog2(N_SRC + 2),
  localparam int IW       = $clog2(N_SRC + N_TRAP),
  localparam int SW       = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_evt,
  input  logic [N_TRAP-1:0] trap_evt,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              mask_go,
  input  logic [MASK_W-1:0] mask_len,
  output logic              vec_req,
  output logic [IW-1:0]     vec_idx,
  output logic [LW-1:0]     vec_lvl,
  input  logic              vec_ack,
  output logic [IW-1:0]     act_idx,
  input  logic              ret_pulse,
  output logic [LW-1:0]     cpu_lvl,
  output logic              stk_ovf
);
  localparam logic [AW-1:0] A_CTRL = AW'(N_SRC);
  localparam logic [AW-1:0] A_TRAP = AW'(N_SRC + 1);

  logic [N_SRC-1:0]      flag, en;
  logic [N_SRC-1:0][2:0] prio;
  logic [N_TRAP-1:0]     trap_q;
  logic                  nest_q;
  logic [MASK_W-1:0]     mask_cnt;
  logic                  mask_on;
  logic                  take, give_back, lvl_we;
  logic [LW-1:0]         new_lvl;

  pic_src_regs #(.N_SRC(N_SRC), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .evt(src_evt),
    .wr_en(reg_we), .wr_sel(reg_addr), .wr_data(reg_wdata),
    .flag(flag), .en(en), .prio(prio)
  );

  pic_select #(.N_SRC(N_SRC), .N_TRAP(N_TRAP), .IW(IW)) u_sel (
    .flag(flag), .en(en), .prio(prio), .trap_flag(trap_q),
    .cur_lvl(cpu_lvl), .mask_on(mask_on),
    .req(vec_req), .idx(vec_idx), .lvl(vec_lvl)
  );

  assign take      = vec_ack & vec_req;
  assign give_back = ret_pulse & ~take;
  assign lvl_we    = reg_we && reg_addr == A_CTRL && !cpu_lvl[3];
  assign new_lvl   = (nest_q && !vec_lvl[3]) ? {1'b0, PRIO_TOP_USER} : vec_lvl;

  pic_level_stack #(.DEPTH(STK_DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_n),
    .push(take), .push_lvl(new_lvl), .pop(give_back),
    .sw_we(lvl_we), .sw_lvl({1'b0, reg_wdata[2:0]}),
    .cur_lvl(cpu_lvl), .ovf(stk_ovf)
  );

  assign mask_on = mask_cnt != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_cnt <= '0;
      nest_q   <= 1'b0;
      trap_q   <= '0;
      act_idx  <= '0;
    end else begin
      if (mask_go)      mask_cnt <= mask_len;
      else if (mask_on) mask_cnt <= mask_cnt - 1'b1;
      if (reg_we && reg_addr == A_CTRL) nest_q <= reg_wdata[4];
      if (reg_we && reg_addr == A_TRAP)
        trap_q <= (trap_q & ~reg_wdata[N_TRAP-1:0]) | trap_evt;
      else
        trap_q <= trap_q | trap_evt;
      if (take) act_idx <= vec_idx;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < A_CTRL)
      reg_rdata = {prio[reg_addr[SW-1:0]], en[reg_addr[SW-1:0]], flag[reg_addr[SW-1:0]]};
    else if (reg_addr == A_CTRL)
      reg_rdata = {nest_q, cpu_lvl};
    else if (reg_addr == A_TRAP)
      reg_rdata = DW'(trap_q);
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int N_SRC = 8,
  parameter int IW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vec_req,
  input logic [IW-1:0] vec_idx,
  input logic [3:0]    vec_lvl,
  input logic          vec_ack,
  input logic [IW-1:0] act_idx,
  input logic [3:0]    cpu_lvl,
  input logic          stk_ovf,
  input logic          nest_on,
  input logic          mask_on
);
  AST_LVL_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> vec_lvl > cpu_lvl); // R3
  AST_TRAP_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req && vec_lvl[3] |-> vec_idx >= IW'(N_SRC)); // R4
  AST_ACT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ack && vec_req |=> act_idx == $past(vec_idx)); // R5
  AST_ENTRY_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ack && vec_req && (vec_lvl[3] || !nest_on) |=> cpu_lvl == $past(vec_lvl)); // R5
  AST_NEST_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ack && vec_req && !vec_lvl[3] && nest_on |=> cpu_lvl == 4'd7); // R6
  AST_MASK_ONLY_L7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_on && vec_req && !vec_lvl[3] |-> vec_lvl == 4'd7); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf |=> stk_ovf); // R11
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_SRC(N_SRC), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .vec_req(vec_req), .vec_idx(vec_idx),
  .vec_lvl(vec_lvl), .vec_ack(vec_ack), .act_idx(act_idx),
  .cpu_lvl(cpu_lvl), .stk_ovf(stk_ovf), .nest_on(nest_q), .mask_on(mask_on)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int CLK_NS = 10;
  localparam int N = 8;
  localparam int NT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_evt = '0;
  logic [NT-1:0] trap_evt = '0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [4:0] reg_wdata = '0;
  logic [4:0] reg_rdata;
  logic mask_go = 1'b0;
  logic [7:0] mask_len = '0;
  logic vec_req, vec_ack = 1'b0, ret_pulse = 1'b0, stk_ovf;
  logic [3:0] vec_idx, act_idx, vec_lvl, cpu_lvl;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic       m_flag [N];
  logic       m_en   [N];
  logic [2:0] m_prio [N];
  logic [3:0] m_lvl;

  always #(CLK_NS/2) clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .trap_evt(trap_evt),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mask_go(mask_go), .mask_len(mask_len), .vec_req(vec_req), .vec_idx(vec_idx),
    .vec_lvl(vec_lvl), .vec_ack(vec_ack), .act_idx(act_idx), .ret_pulse(ret_pulse),
    .cpu_lvl(cpu_lvl), .stk_ovf(stk_ovf)
  );

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  task automatic wr(int a, int d);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 5'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    reg_addr = 4'(a);
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic ack();
    vec_ack = 1'b1; @(negedge clk); vec_ack = 1'b0;
  endtask

  task automatic ret();
    ret_pulse = 1'b1; @(negedge clk); ret_pulse = 1'b0;
  endtask

  task automatic trap(int t);
    trap_evt[t] = 1'b1; @(negedge clk); trap_evt = '0;
  endtask

  // expected {req, idx, lvl} from the shadow of registers, no mask, no trap
  function automatic logic [8:0] model_vec();
    logic hit = 1'b0;
    logic [2:0] best = 3'd0;
    int sel = 0;
    for (int i = 0; i < N; i++)
      if (m_flag[i] && m_en[i] && m_prio[i] != 0 && {1'b0, m_prio[i]} > m_lvl &&
          (!hit || m_prio[i] > best)) begin
        hit = 1'b1; best = m_prio[i]; sel = i;
      end
    return hit ? {1'b1, 4'(sel), 1'b0, best} : 9'd0;
  endfunction

  task automatic chk_vec(string tag, int req, int idx, int lvl);
    chk({tag, " req"}, int'(vec_req), req);
    if (req != 0) begin
      chk({tag, " idx"}, int'(vec_idx), idx);
      chk({tag, " lvl"}, int'(vec_lvl), lvl);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int d;
    logic [8:0] e;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 vec_req", int'(vec_req), 0);
    chk("R1 cpu_lvl", int'(cpu_lvl), 0);
    chk("R1 stk_ovf", int'(stk_ovf), 0);
    rd(0, d); chk("R1 src0 word", d, 5'h10);
    rd(N-1, d); chk("R1 last src word", d, 5'h10);
    rd(N+1, d); chk("R1 trap status", d, 0);

    // R3/R4 constrained random against the shadow model
    for (int i = 0; i < N; i++) begin m_flag[i] = 0; m_en[i] = 0; m_prio[i] = 3'd4; end
    m_lvl = 0;
    for (int k = 0; k < 300; k++) begin
      if ($urandom % 5 == 0) begin
        int l = int'($urandom % 8);
        wr(N, l); m_lvl = 4'(l);
      end else begin
        int a = int'($urandom % N);
        int w = int'($urandom % 32);
        wr(a, w);
        m_flag[a] = w[0]; m_en[a] = w[1]; m_prio[a] = w[4:2];
      end
      e = model_vec();
      chk("R3 R4 random req", int'(vec_req), int'(e[8]));
      if (e[8]) begin
        chk("R4 random idx", int'(vec_idx), int'(e[7:4]));
        chk("R4 random lvl", int'(vec_lvl), int'(e[3:0]));
      end
      chk("R9 random cpu_lvl", int'(cpu_lvl), int'(m_lvl));
    end
    for (int i = 0; i < N; i++) wr(i, 0);
    wr(N, 0);

    // R2 event sets flag; event wins over a same-cycle clear
    src_evt[3] = 1'b1; @(negedge clk); src_evt = '0;
    rd(3, d); chk("R2 event sets flag", d, 1);
    src_evt[3] = 1'b1; wr(3, 0); src_evt = '0;
    rd(3, d); chk("R2 event beats clear", d, 1);
    wr(3, 0);

    // R3 priority 0 and disabled sources never requested
    wr(0, 5'h03); chk_vec("R3 prio0", 0, 0, 0);
    wr(1, 5'h0D); chk_vec("R3 disabled", 0, 0, 0);
    wr(1, 5'h0F); chk_vec("R3 enabled", 1, 1, 3);
    wr(0, 0); wr(1, 0);

    // R4 tie break lowest index
    wr(5, 5'h17); wr(2, 5'h17); wr(6, 5'h13);
    chk_vec("R4 tie", 1, 2, 5);

    // R5 entry
    ack();
    chk("R5 cpu_lvl", int'(cpu_lvl), 5);
    chk("R5 act_idx", int'(act_idx), 2);
    chk("R5 req after entry", int'(vec_req), 0);

    // R7 return re-requests pending flag
    ret();
    chk("R7 restored lvl", int'(cpu_lvl), 0);
    chk_vec("R7 re-request", 1, 2, 5);

    // R6 nesting disable
    wr(N, 5'h10);
    ack();
    chk("R6 nest lvl", int'(cpu_lvl), 7);
    chk("R6 nest req", int'(vec_req), 0);
    ret();
    chk("R6 nest return", int'(cpu_lvl), 0);
    wr(N, 0);
    wr(2, 0); wr(5, 0); wr(6, 0);

    // R8 masking window
    wr(0, 5'h17); chk_vec("R8 before mask", 1, 0, 5);
    mask_go = 1'b1; mask_len = 8'd4; @(negedge clk); mask_go = 1'b0;
    chk("R8 masked lvl5", int'(vec_req), 0);
    wr(1, 5'h1F); chk_vec("R8 lvl7 passes", 1, 1, 7);
    wr(1, 0); chk("R8 still masked", int'(vec_req), 0);
    @(negedge clk); chk("R8 last masked cycle", int'(vec_req), 0);
    @(negedge clk); chk_vec("R8 window over", 1, 0, 5);

    // R9 level 7 write blocks all user sources
    wr(N, 7); chk("R9 lvl7 blocks", int'(vec_req), 0);
    wr(1, 5'h1F); chk("R9 prio7 blocked", int'(vec_req), 0);
    wr(N, 0); chk_vec("R9 restore", 1, 1, 7);
    wr(1, 0);

    // R10 trap sources
    wr(N, 7);
    trap(1);
    rd(N+1, d); chk("R10 trap status", d, 2);
    chk_vec("R10 trap over lvl7", 1, N+1, 9);
    ack();
    chk("R10 trap lvl", int'(cpu_lvl), 9);
    chk("R10 trap act_idx", int'(act_idx), N+1);
    wr(N, 0); chk("R9 write ignored at trap lvl", int'(cpu_lvl), 9);
    wr(N+1, 2); rd(N+1, d); chk("R10 W1C", d, 0);
    ret(); chk("R10 return", int'(cpu_lvl), 7);
    chk("R10 no req at 7", int'(vec_req), 0);
    wr(N, 0); chk_vec("R10 user back", 1, 0, 5);
    wr(0, 0);

    // R11 stack overflow and empty pop
    for (int k = 1; k <= 7; k++) begin
      wr(k-1, (k << 2) | 3);
      chk_vec("R11 climb", 1, k-1, k);
      ack();
      chk("R11 climb lvl", int'(cpu_lvl), k);
    end
    trap(0); ack(); chk("R11 trap0 lvl", int'(cpu_lvl), 8);
    chk("R11 no ovf at full", int'(stk_ovf), 0);
    trap(1); ack(); chk("R11 trap1 lvl", int'(cpu_lvl), 9);
    chk("R11 ovf set", int'(stk_ovf), 1);
    ret(); chk("R11 first pop", int'(cpu_lvl), 7);
    for (int k = 0; k < 7; k++) ret();
    chk("R11 unwound", int'(cpu_lvl), 0);
    ret(); chk("R11 empty pop", int'(cpu_lvl), 0);
    chk("R11 ovf sticky", int'(stk_ovf), 1);

    summary();
  end
endmodule